// File: doc/BRIEF.md
# Line-Frequency Tracking Sample Timer

This block paces analog-to-digital conversions so that a fixed number of samples fall at equal spacing across every cycle of an AC line. Its input is a squared-up zero-crossing signal, which is asynchronous to the timer clock. The block measures each line cycle in timer-clock ticks between successive rising edges. From that measurement it derives a sampling interval, which is the measured period divided by the samples-per-cycle count N. It then issues N one-cycle conversion-start pulses at that spacing during the following cycle. Because the interval is recomputed on every cycle, sample timing follows slow drift in the line frequency.

The most recent valid period count is presented on an output so that firmware can derive the line frequency. A ready flag rises once a run of consecutive valid cycles has been seen, which tells the consumer that an averaging window of results is complete. A cycle whose measured length is outside a configured window is treated as a glitch or a lost signal. Such a cycle is discarded, and it restarts the averaging run. N is a power of two, so the division is a right shift with truncation.

Top module: `lft_sample_timer`

## Requirements
- R1: While reset is held and after it is released with no input activity, `sample_start` is 0, `period_cnt` is 0 and `avg_ready` is 0.
- R2: `line_sq` passes through a two-flop synchronizer. A rise that is first sampled high at clock edge k is acted on at edge k+2, and the registered outputs change right after that edge. The measured period Tc is the number of clock edges between two such actions.
- R3: On a valid capture, `period_cnt` takes the value Tc. At all other times it holds its value.
- R4: On a valid capture, `sample_start` pulses in the cycle that follows the capture edge. It then pulses again every I = floor(Tc / N) cycles, where N = 2^SAMPLES_LOG2.
- R5: Each valid capture yields exactly N pulses. The sequence stops after the N-th pulse even if the next rise is late. A new valid capture abandons any unfinished sequence and starts a fresh one.
- R6: The first rise after reset only starts the period count. It yields no pulse, no `period_cnt` update and no progress toward `avg_ready`.
- R7: `avg_ready` is 1 exactly when at least AVG_CYCLES valid captures have occurred since reset or since the last invalid capture. It updates together with the capture.
- R8: A capture with Tc < MIN_PERIOD or Tc > MAX_PERIOD is invalid. On an invalid capture, `period_cnt` keeps its value, any running pulse sequence stops with no further pulses until the next valid capture, and `avg_ready` falls.
- R9: The period counter saturates rather than wrapping. A gap longer than 2^CNT_W cycles between rises is therefore always seen as an invalid (over-long) cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sq | input | 1 | Squared line waveform, asynchronous to `clk` |
| sample_start | output | 1 | One-cycle conversion-start pulse |
| period_cnt | output | CNT_W | Last valid period count in clock ticks |
| avg_ready | output | 1 | A full run of consecutive valid cycles has been seen |

## Verification
The bench builds the block with a 10-bit counter, N = 4, a valid window of 16 to 200 ticks and an eight-cycle averaging run. At this size, every period length from below the window to above it (12 through 212) can be swept in turn, so each truncation remainder of the divide-by-four appears. The narrow counter also lets a gap of 1500 cycles drive the counter into saturation. Abrupt changes between long and short periods reach the late-edge stop and the early-edge restart. Short and long glitches placed between runs check that the averaging run is cleared and then rebuilt.

// File: rtl/lft_pkg.sv
package lft_pkg;

   // Outcome of a synchronized rising edge of the line input.
   typedef enum logic [1:0] {
      CAP_NONE = 2'd0,   // no edge this cycle
      CAP_ARM  = 2'd1,   // first edge after reset: start timing only
      CAP_GOOD = 2'd2,   // full period inside the accepted window
      CAP_BAD  = 2'd3    // full period outside the accepted window
   } cap_e;

endpackage

// File: rtl/lft_sync_edge.sv
module lft_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   // Synchronizer chain: stage 0 samples the asynchronous pin.
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/lft_period_meter.sv
module lft_period_meter
   import lft_pkg::*;
#(
   parameter int CNT_W      = 20,
   parameter int MIN_PERIOD = 15000,
   parameter int MAX_PERIOD = 23000,
   parameter int AVG_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output cap_e             verdict,
   output logic [CNT_W:0]   tc,
   output logic [CNT_W-1:0] period_q,
   output logic             avg_ready
);

   localparam int TW = CNT_W + 1;
   localparam int GW = $clog2(AVG_CYCLES + 1);

   logic [CNT_W-1:0] ticks_q;
   logic             armed_q;
   logic [GW-1:0]    run_q;
   logic             in_window;

   // Ticks since the last edge, counting the edge cycle itself.
   assign tc        = {1'b0, ticks_q} + TW'(1);
   assign in_window = (tc >= TW'(MIN_PERIOD)) && (tc <= TW'(MAX_PERIOD));

   always_comb begin
      if (!rise)          verdict = CAP_NONE;
      else if (!armed_q)  verdict = CAP_ARM;
      else if (in_window) verdict = CAP_GOOD;
      else                verdict = CAP_BAD;
   end

   // Free-running tick counter, restarted by every edge, saturating at full scale.
   always_ff @(posedge clk) begin
      if (!rst_n)              ticks_q <= '0;
      else if (rise)           ticks_q <= '0;
      else if (ticks_q != '1)  ticks_q <= ticks_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else if (rise) armed_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         run_q    <= '0;
      end else begin
         case (verdict)
            CAP_GOOD: begin
               period_q <= tc[CNT_W-1:0];
               if (run_q != GW'(AVG_CYCLES)) run_q <= run_q + GW'(1);
            end
            CAP_BAD:  run_q <= '0;
            default:  ;
         endcase
      end
   end

   assign avg_ready = (run_q == GW'(AVG_CYCLES));

endmodule

// File: rtl/lft_sample_pacer.sv
module lft_sample_pacer #(
   parameter int CNT_W        = 20,
   parameter int SAMPLES_LOG2 = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           halt,
   input  logic [CNT_W:0] tc,
   output logic           pulse
);

   localparam int TW      = CNT_W + 1;
   localparam int LW      = SAMPLES_LOG2 + 1;
   localparam int NSAMP   = 1 << SAMPLES_LOG2;
   localparam bit MULTI   = (NSAMP > 1);

   logic [TW-1:0] interval;
   logic [TW-1:0] ivl_q;
   logic [TW-1:0] tmr_q;
   logic [LW-1:0] left_q;
   logic          active_q;

   // Power-of-two sample count: the divide is a truncating shift.
   assign interval = tc >> SAMPLES_LOG2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse    <= 1'b0;
         ivl_q    <= '0;
         tmr_q    <= '0;
         left_q   <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         pulse    <= 1'b1;
         ivl_q    <= interval;
         tmr_q    <= interval - TW'(1);
         left_q   <= LW'(NSAMP - 1);
         active_q <= MULTI;
      end else if (halt) begin
         pulse    <= 1'b0;
         active_q <= 1'b0;
      end else if (active_q) begin
         if (tmr_q == '0) begin
            pulse  <= 1'b1;
            tmr_q  <= ivl_q - TW'(1);
            left_q <= left_q - LW'(1);
            if (left_q == LW'(1)) active_q <= 1'b0;
         end else begin
            pulse <= 1'b0;
            tmr_q <= tmr_q - TW'(1);
         end
      end else begin
         pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/lft_sample_timer.sv
module lft_sample_timer
   import lft_pkg::*;
#(
   parameter int CNT_W        = 20,
   parameter int SAMPLES_LOG2 = 5,
   parameter int MIN_PERIOD   = 15000,
   parameter int MAX_PERIOD   = 23000,
   parameter int AVG_CYCLES   = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_sq,
   output logic             sample_start,
   output logic [CNT_W-1:0] period_cnt,
   output logic             avg_ready
);

   // Elaboration-time parameter checks.
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MAX_PERIOD >= (2 ** CNT_W)) begin : g_chk_max
      $error("MAX_PERIOD must fit below the counter full scale");
   end
   if (MIN_PERIOD < (1 << SAMPLES_LOG2)) begin : g_chk_min
      $error("MIN_PERIOD must give an interval of at least one tick");
   end
   if (MIN_PERIOD > MAX_PERIOD) begin : g_chk_window
      $error("MIN_PERIOD exceeds MAX_PERIOD");
   end
   if (AVG_CYCLES < 1) begin : g_chk_avg
      $error("AVG_CYCLES must be positive");
   end

   logic           rise;
   cap_e           verdict;
   logic [CNT_W:0] tc;
   logic           cap_good;
   logic           cap_bad;

   lft_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_sq),
      .rise     (rise)
   );

   lft_period_meter #(
      .CNT_W      (CNT_W),
      .MIN_PERIOD (MIN_PERIOD),
      .MAX_PERIOD (MAX_PERIOD),
      .AVG_CYCLES (AVG_CYCLES)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .verdict   (verdict),
      .tc        (tc),
      .period_q  (period_cnt),
      .avg_ready (avg_ready)
   );

   assign cap_good = (verdict == CAP_GOOD);
   assign cap_bad  = (verdict == CAP_BAD);

   lft_sample_pacer #(
      .CNT_W        (CNT_W),
      .SAMPLES_LOG2 (SAMPLES_LOG2)
   ) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_good),
      .halt  (cap_bad),
      .tc    (tc),
      .pulse (sample_start)
   );

endmodule

// File: rtl/lft_sample_timer_chk.sv
module lft_sample_timer_chk #(
   parameter int CNT_W        = 20,
   parameter int SAMPLES_LOG2 = 5,
   parameter int MIN_PERIOD   = 15000,
   parameter int MAX_PERIOD   = 23000,
   parameter int AVG_CYCLES   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_start,
   input logic [CNT_W-1:0] period_cnt,
   input logic             avg_ready,
   input logic             cap_good,
   input logic             cap_bad
);

   localparam int NSAMP = 1 << SAMPLES_LOG2;
   localparam int SW    = SAMPLES_LOG2 + 2;
   localparam int RW    = $clog2(AVG_CYCLES + 1) + 1;

   logic          loaded_q;
   logic [SW-1:0] seen_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded_q <= 1'b0;
         seen_q   <= '0;
         run_q    <= '0;
      end else begin
         if (cap_good) loaded_q <= 1'b1;
         if (cap_good)          seen_q <= '0;
         else if (sample_start) seen_q <= seen_q + SW'(1);
         if (cap_bad) run_q <= '0;
         else if (cap_good && run_q != RW'(AVG_CYCLES)) run_q <= run_q + RW'(1);
      end
   end

   // R6: no pulse before the first valid capture
   p_no_early_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_start |-> loaded_q);

   // R5: never more than N pulses per capture
   p_pulse_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_start |-> (seen_q < SW'(NSAMP)));

   // R4: a valid capture launches a pulse right away
   p_load_pulses_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_good |=> sample_start);

   // R3: period output moves only on a valid capture
   p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_good |=> $stable(period_cnt));

   // R8: reported period is always inside the window once set
   p_period_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (period_cnt != '0) |-> (period_cnt >= CNT_W'(MIN_PERIOD) && period_cnt <= CNT_W'(MAX_PERIOD)));

   // R8: an invalid capture drops the ready flag
   p_bad_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_bad |=> !avg_ready);

   // R7: ready only after a full run of valid captures
   p_ready_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      avg_ready |-> (run_q == RW'(AVG_CYCLES)));

   // R7: ready rises only on a valid capture
   p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(avg_ready) |-> $past(cap_good));

endmodule

bind lft_sample_timer lft_sample_timer_chk #(
   .CNT_W        (CNT_W),
   .SAMPLES_LOG2 (SAMPLES_LOG2),
   .MIN_PERIOD   (MIN_PERIOD),
   .MAX_PERIOD   (MAX_PERIOD),
   .AVG_CYCLES   (AVG_CYCLES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_start (sample_start),
   .period_cnt   (period_cnt),
   .avg_ready    (avg_ready),
   .cap_good     (cap_good),
   .cap_bad      (cap_bad)
);

// File: tb/lft_sample_timer_bench.sv
module lft_sample_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 10;
   localparam int LOG2       = 2;
   localparam int NSAMP      = 1 << LOG2;
   localparam int MINP       = 16;
   localparam int MAXP       = 200;
   localparam int AVG        = 8;
   localparam int WATCHDOG   = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             line_sq = 1'b0;
   logic             sample_start;
   logic [CNT_W-1:0] period_cnt;
   logic             avg_ready;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lft_sample_timer #(
      .CNT_W        (CNT_W),
      .SAMPLES_LOG2 (LOG2),
      .MIN_PERIOD   (MINP),
      .MAX_PERIOD   (MAXP),
      .AVG_CYCLES   (AVG),
      .SYNC_STAGES  (2)
   ) u_lft_sample_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_sq      (line_sq),
      .sample_start (sample_start),
      .period_cnt   (period_cnt),
      .avg_ready    (avg_ready)
   );

   int vectors = 0;
   int fails   = 0;
   int t       = 0;
   bit done    = 0;

   // Arithmetic expectation state derived from the requirements.
   int prev_rise  = 0;
   bit have_prev  = 0;
   bit pend       = 0;
   bit pend_first = 0;
   int pend_t     = 0;
   int pend_tc    = 0;
   bit seq_on     = 0;
   int seq_start  = 0;
   int seq_i      = 1;
   int good       = 0;
   int exp_period = 0;

   task automatic chk(string what, string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] step %0d: actual %0d expected %0d", what, tag, t, act, exp);
      end
   endtask

   task automatic step(bit val, string tag);
      int exp_s;
      @(negedge clk);
      t++;
      // R2: a rise driven at step k is acted on three steps later
      if (pend && t == pend_t) begin
         pend = 0;
         if (!pend_first) begin
            if (pend_tc >= MINP && pend_tc <= MAXP) begin
               exp_period = pend_tc;
               seq_on     = 1;
               seq_start  = t;
               seq_i      = pend_tc >> LOG2;
               if (good < AVG) good++;
            end else begin
               seq_on = 0;
               good   = 0;
            end
         end
      end
      exp_s = (seq_on && ((t - seq_start) % seq_i == 0) &&
               ((t - seq_start) / seq_i < NSAMP)) ? 1 : 0;
      chk("R4 sample_start", tag, int'(sample_start), exp_s);
      chk("R3 period_cnt", tag, int'(period_cnt), exp_period);
      chk("R7 avg_ready", tag, int'(avg_ready), (good == AVG) ? 1 : 0);
      if (val && !line_sq) begin
         pend       = 1;
         pend_t     = t + 3;
         pend_first = !have_prev;
         pend_tc    = t - prev_rise;
         prev_rise  = t;
         have_prev  = 1;
      end
      line_sq = val;
   endtask

   task automatic wave(int p, int reps, string tag);
      for (int r = 0; r < reps; r++)
         for (int j = 0; j < p; j++)
            step((j < p / 2) ? 1'b1 : 1'b0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      // R1: reset values
      chk("R1 sample_start", "R1 reset", int'(sample_start), 0);
      chk("R1 period_cnt", "R1 reset", int'(period_cnt), 0);
      chk("R1 avg_ready", "R1 reset", int'(avg_ready), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) step(1'b0, "R1 idle");

      // R6: first edge only arms
      wave(40, 1, "R6 first edge");
      wave(40, 3, "R2 R4 steady");
      // R7: run of valid cycles raises ready
      wave(48, 8, "R7 eight valid");
      // R8: short glitch cycle, then rebuild the run
      wave(12, 2, "R8 short period");
      wave(30, 9, "R7 R8 rebuild");
      // R8: over-long cycle
      wave(250, 2, "R8 long period");
      wave(36, 3, "R8 recover");
      // R9: gap far beyond the counter range
      for (int i = 0; i < 1500; i++) step(1'b1, "R9 long gap");
      for (int i = 0; i < 20; i++) step(1'b0, "R9 long gap");
      wave(50, 3, "R9 after gap");
      // R5: late edge stops after N pulses, early edge restarts
      wave(40, 2, "R5 late edge");
      wave(180, 2, "R5 late edge");
      wave(190, 2, "R5 early edge");
      wave(20, 3, "R5 early edge");
      // R2 R4 R5 R8: sweep every period across and past the window
      for (int p = 12; p <= 212; p++) wave(p, 2, "R2 R4 R5 R8 sweep");
      for (int i = 0; i < 20; i++) step(1'b0, "R5 tail");
      finish_run();
   end

endmodule